// File: doc/BRIEF.md
# Pipelined Constant Divider by Shift-Add Series

This block computes the integer quotient of an unsigned dividend by a fixed odd divisor chosen at elaboration time, without any general-purpose division hardware. It relies on the fact that every odd divisor D has a whole-number partner M such that D·M equals 2^N − 1. The dividend is multiplied by M. The reciprocal of 2^N − 1 is then built as 2^-N times a chain of factors of the form (1 + 2^-(N·2^i)). Each factor costs one shift and one add.

The pipeline has three kinds of stage. The entry stage forms z·M with a few guard fraction bits and applies the first factor. Each series stage after it applies the next factor with twice the shift. A fixup stage truncates to an integer estimate, forms the remainder z − q·D, and moves the estimate up or down by one when the remainder falls outside [0, D). The fixup stage names its three outcomes KEEP, RAISE and LOWER. A valid flag travels with every word, so the block accepts a new dividend on every clock.

Top module: `const_div_series`

## Requirements
- R1: Parameters are the divisor D (odd, at least 3), the exponent N with D dividing 2^N − 1, the width W and the guard bit count G. M is derived as (2^N − 1)/D. The pairs (D,N) = (3,4), (7,6) and (11,10) give correct quotients.
- R2: When out_valid is high, out_quotient equals floor(z / D) for the dividend z that produced it, for every W-bit z.
- R3: With K the smallest k ≥ 1 such that N·2^k ≥ W + 1, the result appears after K + 1 register stages. Counting the rising edge that samples in_valid as the first, out_valid and the quotient show up after the (K+1)-th rising edge.
- R4: One dividend may be presented on every cycle with no gap. Results come out in the order the dividends went in.
- R5: A cycle with in_valid low produces no out_valid K + 1 cycles later, whatever value in_dividend holds.
- R6: While rst_n is low, out_valid is low. Dividends in flight when reset is asserted produce no result after it is released.
- R7: Exact multiples k·D yield k, and k·D − 1 yields k − 1. This holds at the top of the range, including z = 2^W − 1, and for z = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the valid flags |
| in_valid | input | 1 | Dividend on in_dividend is to be processed |
| in_dividend | input | W | Unsigned dividend |
| out_valid | output | 1 | out_quotient holds a result |
| out_quotient | output | W | floor(dividend / D) |

## Verification
The sharpest corner is an exact multiple of D. There the truncated series value lands just below the integer, so a design that skipped or misordered the RAISE correction would return k − 1 instead of k. The largest dividends stress the guard and carry bits; a pipeline one bit too narrow would wrap and return a small quotient. Back-to-back streams with random bubbles, plus a reset that lands while results are in flight, expose a valid flag that lags or leads its data, or that leaks a stale result. The three divisor configurations cover a case with one series stage, with two and with three, so a wrong shift schedule or stage count shows up as wrong low quotient bits.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    // Outcome of the final remainder check.
    typedef enum logic [1:0] {
        FIX_KEEP  = 2'd0,
        FIX_RAISE = 2'd1,
        FIX_LOWER = 2'd2
    } fix_e;

    // Number of (1 + 2^-(n*2^i)) factors needed so that the series error
    // stays below one half of a quotient unit for a width-bit dividend.
    function automatic int series_depth(input int width, input int n);
        int k;
        k = 1;
        while ((n << k) < width + 1) begin
            k++;
        end
        return k;
    endfunction

endpackage

// File: rtl/cdiv_entry.sv
module cdiv_entry #(
    parameter int W  = 16,
    parameter int N  = 6,
    parameter int M  = 9,
    parameter int G  = 3,
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          v_i,
    input  logic [W-1:0]  z_i,
    output logic          v_o,
    output logic [W-1:0]  z_o,
    output logic [AW-1:0] acc_o
);

    logic [AW-1:0] prod_w;
    logic [AW-1:0] scaled_w;
    logic [AW-1:0] step_w;

    always_comb begin
        prod_w   = AW'(z_i) * AW'(M);
        scaled_w = prod_w << G;
        step_w   = scaled_w + (scaled_w >> N);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_o <= 1'b0;
        end else begin
            v_o <= v_i;
        end
    end

    always_ff @(posedge clk) begin
        z_o   <= z_i;
        acc_o <= step_w;
    end

    // R4
    entry_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_i |=> (v_o && z_o == $past(z_i)));

    // R5
    entry_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !v_i |=> !v_o);

endmodule

// File: rtl/cdiv_series_stage.sv
module cdiv_series_stage #(
    parameter int W  = 16,
    parameter int AW = 24,
    parameter int SH = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          v_i,
    input  logic [W-1:0]  z_i,
    input  logic [AW-1:0] acc_i,
    output logic          v_o,
    output logic [W-1:0]  z_o,
    output logic [AW-1:0] acc_o
);

    logic [AW-1:0] grown_w;

    always_comb begin
        grown_w = acc_i + (acc_i >> SH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_o <= 1'b0;
        end else begin
            v_o <= v_i;
        end
    end

    always_ff @(posedge clk) begin
        z_o   <= z_i;
        acc_o <= grown_w;
    end

    // R3
    stage_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_i |=> v_o);

    // R5
    stage_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !v_i |=> !v_o);

    // R2
    stage_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_i |=> (acc_o >= $past(acc_i)));

endmodule

// File: rtl/cdiv_fixup.sv
module cdiv_fixup
    import cdiv_pkg::*;
#(
    parameter int W  = 16,
    parameter int D  = 7,
    parameter int N  = 6,
    parameter int G  = 3,
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          v_i,
    input  logic [W-1:0]  z_i,
    input  logic [AW-1:0] acc_i,
    output logic          v_o,
    output logic [W-1:0]  q_o
);

    localparam int QW = AW - G - N;
    localparam int DW = $clog2(D + 1);
    localparam int RW = QW + DW + 2;
    localparam logic signed [RW-1:0] D_S = RW'(D);

    logic [QW-1:0]        q_raw;
    logic [RW-1:0]        back_w;
    logic signed [RW-1:0] rem_s;
    fix_e                 sel;
    logic [QW-1:0]        q_adj;
    logic [W-1:0]         z_q;

    always_comb begin
        q_raw  = QW'(acc_i >> (G + N));
        back_w = RW'(q_raw) * RW'(D);
        rem_s  = $signed(RW'(z_i)) - $signed(back_w);
        if (rem_s < 0) begin
            sel = FIX_LOWER;
        end else if (rem_s >= D_S) begin
            sel = FIX_RAISE;
        end else begin
            sel = FIX_KEEP;
        end
    end

    always_comb begin
        unique case (sel)
            FIX_KEEP:  q_adj = q_raw;
            FIX_RAISE: q_adj = q_raw + QW'(1);
            FIX_LOWER: q_adj = q_raw - QW'(1);
            default:   q_adj = q_raw;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_o <= 1'b0;
        end else begin
            v_o <= v_i;
        end
    end

    always_ff @(posedge clk) begin
        q_o <= W'(q_adj);
        z_q <= z_i;
    end

    // R2
    quot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_o |-> ((RW'(q_o) * RW'(D) <= RW'(z_q)) &&
                 (RW'(z_q) - RW'(q_o) * RW'(D) < RW'(D))));

    // R2
    estimate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_i |-> (sel != FIX_LOWER));

    // R3
    fix_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_i |=> v_o);

    // R5
    fix_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !v_i |=> !v_o);

endmodule

// File: rtl/const_div_series.sv
module const_div_series
    import cdiv_pkg::*;
#(
    parameter int W = 16,
    parameter int D = 7,
    parameter int N = 6,
    parameter int G = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_dividend,
    output logic         out_valid,
    output logic [W-1:0] out_quotient
);

    localparam int M  = ((2 ** N) - 1) / D;
    localparam int K  = series_depth(W, N);
    localparam int MW = $clog2(M + 1);
    localparam int AW = W + MW + G + 1;

    logic          v_s   [K];
    logic [W-1:0]  z_s   [K];
    logic [AW-1:0] acc_s [K];

    cdiv_entry #(
        .W (W),
        .N (N),
        .M (M),
        .G (G),
        .AW(AW)
    ) u_entry (
        .clk  (clk),
        .rst_n(rst_n),
        .v_i  (in_valid),
        .z_i  (in_dividend),
        .v_o  (v_s[0]),
        .z_o  (z_s[0]),
        .acc_o(acc_s[0])
    );

    for (genvar i = 1; i < K; i++) begin : g_series
        cdiv_series_stage #(
            .W (W),
            .AW(AW),
            .SH(N << i)
        ) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .v_i  (v_s[i-1]),
            .z_i  (z_s[i-1]),
            .acc_i(acc_s[i-1]),
            .v_o  (v_s[i]),
            .z_o  (z_s[i]),
            .acc_o(acc_s[i])
        );
    end

    cdiv_fixup #(
        .W (W),
        .D (D),
        .N (N),
        .G (G),
        .AW(AW)
    ) u_fixup (
        .clk  (clk),
        .rst_n(rst_n),
        .v_i  (v_s[K-1]),
        .z_i  (z_s[K-1]),
        .acc_i(acc_s[K-1]),
        .v_o  (out_valid),
        .q_o  (out_quotient)
    );

endmodule

// File: tb/const_div_series_test.sv
module const_div_series_test;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] in_dividend;
    logic        ov [3];
    logic [15:0] oq [3];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // divisor and expected latency (K+1) for each instance, from R1 and R3
    localparam int DV   [3] = '{7, 3, 11};
    localparam int LATV [3] = '{3, 4, 2};

    // {dividend, quotient by 7}; R7 boundary vectors included
    localparam logic [31:0] VEC [16] = '{
        {16'd0,     16'd0},    {16'd6,     16'd0},
        {16'd7,     16'd1},    {16'd13,    16'd1},
        {16'd14,    16'd2},    {16'd49,    16'd7},
        {16'd63,    16'd9},    {16'd64,    16'd9},
        {16'd700,   16'd100},  {16'd1000,  16'd142},
        {16'd9999,  16'd1428}, {16'd12345, 16'd1763},
        {16'd65527, 16'd9361}, {16'd65533, 16'd9361},
        {16'd65534, 16'd9362}, {16'd65535, 16'd9362}
    };

    int exp_q [3][$];
    int due_q [3][$];
    int z_qu  [3][$];

    const_div_series #(.W(16), .D(7), .N(6), .G(3)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dividend(in_dividend),
        .out_valid(ov[0]), .out_quotient(oq[0])
    );

    const_div_series #(.W(16), .D(3), .N(4), .G(3)) uut_d3 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dividend(in_dividend),
        .out_valid(ov[1]), .out_quotient(oq[1])
    );

    const_div_series #(.W(16), .D(11), .N(10), .G(3)) uut_d11 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dividend(in_dividend),
        .out_valid(ov[2]), .out_quotient(oq[2])
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic send(input bit v, input int z, input int q7);
        @(negedge clk);
        in_valid    = v;
        in_dividend = 16'(z);
        if (v) begin
            for (int j = 0; j < 3; j++) begin
                exp_q[j].push_back((j == 0) ? q7 : z / DV[j]);
                due_q[j].push_back(cyc + LATV[j]);
                z_qu[j].push_back(z);
            end
        end
    endtask

    task automatic quiet_check(input string tag);
        for (int j = 0; j < 3; j++) begin
            checks++;
            if (ov[j] !== 1'b0) begin
                fails++;
                $display("FAIL %s d=%0d out_valid actual %0b expected 0", tag, DV[j], ov[j]);
            end
        end
    endtask

    // output monitor: value (R2, R1), timing and order (R3, R4), spurious (R5)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int j = 0; j < 3; j++) begin
                if (ov[j]) begin
                    checks++;
                    if (exp_q[j].size() == 0) begin
                        fails++;
                        $display("FAIL R5 d=%0d spurious out_valid actual 1 expected 0", DV[j]);
                    end else begin
                        int e;
                        int d;
                        int z;
                        e = exp_q[j].pop_front();
                        d = due_q[j].pop_front();
                        z = z_qu[j].pop_front();
                        if (d != cyc) begin
                            fails++;
                            $display("FAIL R3/R4 d=%0d z=%0d result cycle actual %0d expected %0d",
                                     DV[j], z, cyc, d);
                        end
                        checks++;
                        if (int'(oq[j]) != e) begin
                            fails++;
                            $display("FAIL %s d=%0d z=%0d quotient actual %0d expected %0d",
                                     (j == 0) ? "R2" : "R1", DV[j], z, oq[j], e);
                        end
                    end
                end else if (due_q[j].size() > 0 && due_q[j][0] <= cyc) begin
                    checks++;
                    fails++;
                    $display("FAIL R3 d=%0d z=%0d missing result actual none expected %0d",
                             DV[j], z_qu[j][0], exp_q[j][0]);
                    void'(exp_q[j].pop_front());
                    void'(due_q[j].pop_front());
                    void'(z_qu[j].pop_front());
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R4 watchdog expired actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n       = 1'b0;
        in_valid    = 1'b0;
        in_dividend = 16'h0;
        repeat (3) @(negedge clk);
        quiet_check("R6");
        rst_n = 1'b1;
        @(negedge clk);
        quiet_check("R6");

        // vector table, back to back (R2, R4, R7)
        for (int i = 0; i < 16; i++) begin
            send(1'b1, int'(VEC[i][31:16]), int'(VEC[i][15:0]));
        end
        send(1'b0, 0, 0);

        // idle cycles with a changing dividend must give nothing (R5)
        for (int i = 0; i < 8; i++) begin
            send(1'b0, 16'hBEEF + i, 0);
        end

        // low and high sweeps, multiples and neighbours (R2, R7)
        for (int z = 0; z < 1500; z++) begin
            send(1'b1, z, z / 7);
        end
        for (int z = 65535 - 1200; z <= 65535; z++) begin
            send(1'b1, z, z / 7);
        end
        for (int k = 9300; k <= 9362; k++) begin
            send(1'b1, 7 * k, k);
            send(1'b1, 7 * k - 1, k - 1);
        end

        // bubbles mixed into the stream (R4, R5)
        for (int i = 0; i < 300; i++) begin
            send((i % 3) != 1, (i * 2654435) & 16'hFFFF, ((i * 2654435) & 16'hFFFF) / 7);
        end
        send(1'b0, 0, 0);
        repeat (8) send(1'b0, 0, 0);

        // reset while results are in flight (R6)
        for (int i = 0; i < 4; i++) begin
            send(1'b1, 40000 + i, (40000 + i) / 7);
        end
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        for (int j = 0; j < 3; j++) begin
            exp_q[j].delete();
            due_q[j].delete();
            z_qu[j].delete();
        end
        @(negedge clk);
        quiet_check("R6");
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            quiet_check("R6");
        end

        // final pair after reset (R2)
        send(1'b1, 65535, 9362);
        send(1'b1, 0, 0);
        repeat (8) send(1'b0, 0, 0);

        for (int j = 0; j < 3; j++) begin
            checks++;
            if (exp_q[j].size() != 0) begin
                fails++;
                $display("FAIL R3 d=%0d pending results actual %0d expected 0",
                         DV[j], exp_q[j].size());
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule